// File: doc/BRIEF.md
# Scalar Reciprocal Square Root Approximator

This block takes one IEEE-754 single-precision operand and returns an estimate of 1/sqrt(x) in the low 32-bit lane of a 256-bit destination value. The estimate is not correctly rounded. It only has to stay within a fixed relative error bound, and no rounding-mode input exists. The mantissa comes from a small table of segment endpoints with linear interpolation between them. The exponent is halved and negated with one subtraction.

Zeros, subnormals, infinities, negative numbers and NaNs bypass the arithmetic path and return fixed encodings. The 224 bits above the scalar lane come from one of two places. In legacy mode they are the previous destination contents. In VEX mode, bits 127:32 come from a first-source vector and bits 255:128 are cleared. The unit accepts one operand per cycle and returns each result exactly two cycles later.

Top module: `rsqrt_scalar_unit`

## Requirements
- R1: For a positive normal operand x, the result r is a positive normal single-precision value with |r*sqrt(x) - 1| <= 1.5 * 2^-12.
- R2: An operand with a zero exponent field (a signed zero or a subnormal) returns infinity of the operand's sign: 0x7F800000 for sign 0, 0xFF800000 for sign 1.
- R3: A negative operand that is not a NaN and does not have a zero exponent field returns the indefinite value 0xFFC00000. This includes -infinity and negative normals.
- R4: The operand +infinity (0x7F800000) returns +0.0 (0x00000000).
- R5: A NaN operand (exponent 0xFF, nonzero fraction) is returned with bit 22 set and every other bit unchanged. A quiet NaN therefore comes back identical.
- R6: With vex_mode = 0, result bits 255:32 equal the prior_hi value supplied with the same operand.
- R7: With vex_mode = 1, result bits 127:32 equal the src1_hi value supplied with the same operand, and result bits 255:128 are zero.
- R8: out_valid is 0 during reset and is high in exactly the cycles that follow two rising edges after an in_valid cycle. Back-to-back operands give back-to-back results in the same order.
- R9: An operand equal to 4^k (a positive normal with an odd biased exponent and a zero fraction) returns exactly 2^-k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| in_valid | input | 1 | Operand strobe |
| operand | input | 32 | Single-precision source value |
| vex_mode | input | 1 | 0: keep prior upper bits; 1: copy src1_hi and clear bits 255:128 |
| src1_hi | input | 96 | Bits 127:32 of the first-source vector |
| prior_hi | input | 224 | Bits 255:32 of the previous destination value |
| out_valid | output | 1 | Result strobe, two cycles after in_valid |
| result_dest | output | 256 | Destination value with the estimate in bits 31:0 |

## Verification
The bench targets the exact powers of four and the smallest normal. A unit that mishandled the interpolated value 2.0 would give a wrong exponent there, and one that rounded the halved exponent the wrong way would land a factor of two off. Subnormals of both signs are driven so that a unit which classified them as normals would return huge finite values rather than infinities. Negative denormals are kept apart from negative normals so that a unit which checked the sign before the exponent would return the indefinite value for them. Signalling NaNs with nonzero payloads and both signs catch a unit that builds a fresh canonical NaN. The mode select is flipped on every operand, and three operands are sent back to back, which catches a unit that mixes the two merge sources or drops or reorders results.

// File: rtl/rsqrt_pkg.sv
package rsqrt_pkg;

  localparam int SP_W     = 32;
  localparam int SP_EXP_W = 8;
  localparam int SP_MAN_W = 23;
  localparam int SP_BIAS  = 127;

  localparam logic [SP_W-1:0] SP_INDEF   = 32'hFFC0_0000;
  localparam logic [SP_W-1:0] SP_QUIET_B = 32'h0040_0000;

  typedef enum logic [2:0] {
    RS_NORM  = 3'd0,
    RS_ZERO  = 3'd1,
    RS_PINF  = 3'd2,
    RS_INDEF = 3'd3,
    RS_NAN   = 3'd4
  } rs_class_e;

endpackage

// File: rtl/rsqrt_classify.sv
module rsqrt_classify
  import rsqrt_pkg::*;
(
  input  logic [SP_W-1:0] op_word,
  output rs_class_e       op_class,
  output logic [SP_W-1:0] special_word
);

  logic                sgn;
  logic [SP_EXP_W-1:0] exp_f;
  logic [SP_MAN_W-1:0] man_f;

  assign sgn   = op_word[SP_W-1];
  assign exp_f = op_word[SP_W-2 -: SP_EXP_W];
  assign man_f = op_word[SP_MAN_W-1:0];

  always_comb begin
    op_class     = RS_NORM;
    special_word = '0;
    if ((&exp_f) && (|man_f)) begin
      op_class     = RS_NAN;
      special_word = op_word | SP_QUIET_B;
    end else if (exp_f == '0) begin
      op_class     = RS_ZERO;
      special_word = {sgn, {SP_EXP_W{1'b1}}, {SP_MAN_W{1'b0}}};
    end else if (sgn) begin
      op_class     = RS_INDEF;
      special_word = SP_INDEF;
    end else if (&exp_f) begin
      op_class     = RS_PINF;
      special_word = '0;
    end
  end

endmodule

// File: rtl/rsqrt_mant_lut.sv
module rsqrt_mant_lut #(
  parameter int SEG_BITS  = 5,
  parameter int FRAC_BITS = 10,
  parameter int G_FRAC    = 16,
  localparam int IDX_W    = SEG_BITS + FRAC_BITS,
  localparam int G_W      = G_FRAC + 2
) (
  input  logic             odd_half,
  input  logic [IDX_W-1:0] man_idx,
  output logic [G_W-1:0]   g_val
);

  localparam int NSEG  = 1 << SEG_BITS;
  localparam int NENT  = 2 * NSEG;
  localparam int PRD_W = G_W + FRAC_BITS;

  // Node value 2/sqrt(y) scaled by 2^G_FRAC, y = 1 + j/NSEG (h=0) or 2 + 2j/NSEG (h=1)
  function automatic logic [G_W-1:0] node_val(input int j, input int h);
    longint unsigned num;
    longint unsigned root;
    longint unsigned cand;
    num  = (64'd1 << (2*G_FRAC + 2 + SEG_BITS - h)) / 64'(NSEG + j);
    root = 0;
    for (int b = G_W - 1; b >= 0; b--) begin
      cand = root | (64'd1 << b);
      if (cand * cand <= num) root = cand;
    end
    return root[G_W-1:0];
  endfunction

  logic [G_W-1:0] lo_tab [NENT];
  logic [G_W-1:0] hi_tab [NENT];

  for (genvar hh = 0; hh < 2; hh++) begin : g_half
    for (genvar jj = 0; jj < NSEG; jj++) begin : g_seg
      localparam logic [G_W-1:0] LO_V = node_val(jj, hh);
      localparam logic [G_W-1:0] HI_V = node_val(jj + 1, hh);
      assign lo_tab[hh*NSEG + jj] = LO_V;
      assign hi_tab[hh*NSEG + jj] = HI_V;
    end
  end

  logic [SEG_BITS:0]     sel;
  logic [FRAC_BITS-1:0]  frac;
  logic [G_W-1:0]        lo_v;
  logic [G_W-1:0]        step;
  logic [PRD_W-1:0]      prod;
  logic [G_W-1:0]        prod_hi;
  logic [FRAC_BITS-1:0]  prod_lo;
  logic                  rnd;

  assign sel  = {odd_half, man_idx[IDX_W-1 -: SEG_BITS]};
  assign frac = man_idx[FRAC_BITS-1:0];
  assign lo_v = lo_tab[sel];
  assign step = lo_tab[sel] - hi_tab[sel];

  always_comb begin
    prod    = {{FRAC_BITS{1'b0}}, step} * {{G_W{1'b0}}, frac};
    prod_hi = prod[PRD_W-1:FRAC_BITS];
    prod_lo = prod[FRAC_BITS-1:0];
    rnd     = (prod_lo >= FRAC_BITS'(1 << (FRAC_BITS - 1)));
    g_val   = lo_v - prod_hi - G_W'(rnd);
  end

endmodule

// File: rtl/rsqrt_lane_merge.sv
module rsqrt_lane_merge #(
  parameter int UP_W  = 224,
  parameter int SRC_W = 96
) (
  input  logic             vex_mode,
  input  logic [SRC_W-1:0] src1_hi,
  input  logic [UP_W-1:0]  prior_hi,
  output logic [UP_W-1:0]  upper
);

  always_comb begin
    if (vex_mode) upper = {{(UP_W-SRC_W){1'b0}}, src1_hi};
    else          upper = prior_hi;
  end

endmodule

// File: rtl/rsqrt_scalar_unit.sv
module rsqrt_scalar_unit
  import rsqrt_pkg::*;
#(
  parameter int VEC_W     = 128,
  parameter int DEST_W    = 256,
  parameter int SEG_BITS  = 5,
  parameter int FRAC_BITS = 10,
  parameter int G_FRAC    = 16,
  localparam int SRC_W    = VEC_W - SP_W,
  localparam int UP_W     = DEST_W - SP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [SP_W-1:0]   operand,
  input  logic              vex_mode,
  input  logic [SRC_W-1:0]  src1_hi,
  input  logic [UP_W-1:0]   prior_hi,
  output logic              out_valid,
  output logic [DEST_W-1:0] result_dest
);

  localparam int IDX_W   = SEG_BITS + FRAC_BITS;
  localparam int G_W     = G_FRAC + 2;
  localparam int EXP_SUM = 3 * SP_BIAS - 1;

  // reset release synchroniser
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // stage 1 combinational front end
  rs_class_e       cls_nx;
  logic [SP_W-1:0] special_nx;
  logic [G_W-1:0]  g_nx;
  logic [UP_W-1:0] upper_nx;
  logic [SP_EXP_W:0]   exp_diff;
  logic [SP_EXP_W-1:0] exp_nx;
  logic                odd_half;

  rsqrt_classify u_classify (
    .op_word      (operand),
    .op_class     (cls_nx),
    .special_word (special_nx)
  );

  // floor((3*bias - 1 - E) / 2) gives the biased exponent of the estimate before the bump
  assign exp_diff = (SP_EXP_W+1)'(EXP_SUM) - {1'b0, operand[SP_W-2 -: SP_EXP_W]};
  assign exp_nx   = exp_diff[SP_EXP_W:1];
  assign odd_half = ~exp_diff[0];

  rsqrt_mant_lut #(
    .SEG_BITS  (SEG_BITS),
    .FRAC_BITS (FRAC_BITS),
    .G_FRAC    (G_FRAC)
  ) u_mant_lut (
    .odd_half (odd_half),
    .man_idx  (operand[SP_MAN_W-1 -: IDX_W]),
    .g_val    (g_nx)
  );

  rsqrt_lane_merge #(
    .UP_W  (UP_W),
    .SRC_W (SRC_W)
  ) u_lane_merge (
    .vex_mode (vex_mode),
    .src1_hi  (src1_hi),
    .prior_hi (prior_hi),
    .upper    (upper_nx)
  );

  // stage 1 registers
  logic                s1_valid;
  rs_class_e           s1_cls;
  logic [SP_W-1:0]     s1_special;
  logic [SP_EXP_W-1:0] s1_exp;
  logic [G_W-1:0]      s1_g;
  logic [UP_W-1:0]     s1_upper;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) s1_valid <= 1'b0;
    else             s1_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_cls     <= cls_nx;
      s1_special <= special_nx;
      s1_exp     <= exp_nx;
      s1_g       <= g_nx;
      s1_upper   <= upper_nx;
    end
  end

  // stage 2 assembly
  logic                bump;
  logic [SP_EXP_W-1:0] exp_fin;
  logic [SP_MAN_W-1:0] man_fin;
  logic [SP_W-1:0]     lane_nx;
  logic [DEST_W-1:0]   dest_nx;

  always_comb begin
    bump    = s1_g[G_W-1];
    exp_fin = s1_exp + {{(SP_EXP_W-1){1'b0}}, bump};
    man_fin = bump ? '0 : (SP_MAN_W'(s1_g[G_FRAC-1:0]) << (SP_MAN_W - G_FRAC));
    lane_nx = (s1_cls == RS_NORM) ? {1'b0, exp_fin, man_fin} : s1_special;
    dest_nx = {s1_upper, lane_nx};
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) out_valid <= 1'b0;
    else             out_valid <= s1_valid;
  end

  always_ff @(posedge clk) begin
    if (s1_valid) result_dest <= dest_nx;
  end

  // R8
  in_to_s1_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> s1_valid);
  // R8
  s1_to_out_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    s1_valid |=> out_valid);
  // R8
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !s1_valid |=> !out_valid);
  // R1
  lut_norm_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (s1_valid && s1_cls == RS_NORM) |-> (s1_g[G_W-1] ^ s1_g[G_FRAC]));
  // R2
  zero_inf_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && operand[30:23] == 8'h00) |=> ##1
      (result_dest[31:0] == {$past(operand[31], 2), 8'hFF, 23'h0}));
  // R3
  indef_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && operand[31] && operand[30:23] != 8'h00 &&
     !(operand[30:23] == 8'hFF && operand[22:0] != 23'h0)) |=> ##1
      (result_dest[31:0] == 32'hFFC0_0000));
  // R4
  pinf_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && operand == 32'h7F80_0000) |=> ##1 (result_dest[31:0] == 32'h0));
  // R5
  nan_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && operand[30:23] == 8'hFF && operand[22:0] != 23'h0) |=> ##1
      (result_dest[31:0] == ($past(operand, 2) | 32'h0040_0000)));
  // R6
  legacy_keep_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && !vex_mode) |=> ##1 (result_dest[DEST_W-1:SP_W] == $past(prior_hi, 2)));
  // R7
  vex_copy_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && vex_mode) |=> ##1
      (result_dest[DEST_W-1:VEC_W] == '0 && result_dest[VEC_W-1:SP_W] == $past(src1_hi, 2)));

endmodule

// File: tb/rsqrt_scalar_unit_tb.sv
module rsqrt_scalar_unit_tb;

  localparam int NV = 24;
  localparam real ERR_BOUND = 1.5 / 4096.0;

  localparam logic [31:0] V_OP [NV] = '{
    32'h3F80_0000, 32'h4080_0000, 32'h3E80_0000, 32'h0080_0000,
    32'h4000_0000, 32'h3FC0_0000, 32'h7F7F_FFFF, 32'h3FFF_FFFF,
    32'h407F_FFFF, 32'h42C8_0000, 32'h3DCC_CCCD,
    32'h0000_0000, 32'h8000_0000, 32'h0000_0001, 32'h807F_FFFF,
    32'hBF80_0000, 32'hFF80_0000, 32'h8080_0000,
    32'h7F80_0000,
    32'h7F80_0001, 32'hFFA0_0005, 32'h7FC1_2345, 32'hFFC0_0000,
    32'h3F35_04F3
  };
  localparam logic [31:0] V_EXP [NV] = '{
    32'h3F80_0000, 32'h3F00_0000, 32'h4000_0000, 32'h5F00_0000,
    32'h0, 32'h0, 32'h0, 32'h0,
    32'h0, 32'h0, 32'h0,
    32'h7F80_0000, 32'hFF80_0000, 32'h7F80_0000, 32'hFF80_0000,
    32'hFFC0_0000, 32'hFFC0_0000, 32'hFFC0_0000,
    32'h0000_0000,
    32'h7FC0_0001, 32'hFFE0_0005, 32'h7FC1_2345, 32'hFFC0_0000,
    32'h0
  };
  localparam logic [NV-1:0] APX_MASK = 24'h8007F0;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [31:0]  operand;
  logic         vex_mode;
  logic [95:0]  src1_hi;
  logic [223:0] prior_hi;
  logic         out_valid;
  logic [255:0] result_dest;

  int checks;
  int fails;
  bit done;

  rsqrt_scalar_unit u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .operand     (operand),
    .vex_mode    (vex_mode),
    .src1_hi     (src1_hi),
    .prior_hi    (prior_hi),
    .out_valid   (out_valid),
    .result_dest (result_dest)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic string req_of(int i);
    if (i < 4) return "R9";
    if (i < 11 || i == 23) return "R1";
    if (i < 15) return "R2";
    if (i < 18) return "R3";
    if (i == 18) return "R4";
    return "R5";
  endfunction

  function automatic real f32_val(logic [31:0] b);
    int e;
    e = int'(b[30:23]) - 127;
    return (1.0 + real'(b[22:0]) / 8388608.0) * (2.0 ** real'(e));
  endfunction

  task automatic chk_bit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic chk32(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_up(string tag, logic [223:0] act, logic [223:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_approx(logic [31:0] op, logic [31:0] res);
    real x;
    real y;
    real err;
    checks++;
    if (res[31] || res[30:23] == 8'h00 || res[30:23] == 8'hFF) begin
      fails++;
      $display("FAIL R1 actual=%h expected=positive normal for op %h", res, op);
    end else begin
      x = f32_val(op);
      y = f32_val(res);
      err = y * $sqrt(x) - 1.0;
      if (err < 0.0) err = -err;
      if (err > ERR_BOUND) begin
        fails++;
        $display("FAIL R1 op=%h actual=%h relerr=%e expected<=%e", op, res, err, ERR_BOUND);
      end
    end
  endtask

  function automatic logic [223:0] prior_pat(int i);
    logic [223:0] p;
    for (int k = 0; k < 7; k++) p[k*32 +: 32] = 32'hA5A5_0000 ^ (i << 8) ^ k;
    return p;
  endfunction

  function automatic logic [95:0] src_pat(int i);
    logic [95:0] s;
    for (int k = 0; k < 3; k++) s[k*32 +: 32] = 32'h5A5A_0010 ^ (i << 8) ^ k;
    return s;
  endfunction

  function automatic logic [223:0] up_exp(int i, logic vx);
    return vx ? {128'b0, src_pat(i)} : prior_pat(i);
  endfunction

  task automatic drive(int i, logic vx);
    in_valid = 1'b1;
    operand  = V_OP[i];
    vex_mode = vx;
    src1_hi  = src_pat(i);
    prior_hi = prior_pat(i);
  endtask

  task automatic check_lane(int i, logic vx);
    if (APX_MASK[i]) chk_approx(V_OP[i], result_dest[31:0]);
    else             chk32(req_of(i), result_dest[31:0], V_EXP[i]);
    chk_up(vx ? "R7" : "R6", result_dest[255:32], up_exp(i, vx));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog actual=hung expected=completion");
    finish_run();
  end

  initial begin
    checks   = 0;
    fails    = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    operand  = '0;
    vex_mode = 1'b0;
    src1_hi  = '0;
    prior_hi = '0;

    repeat (3) @(negedge clk);
    chk_bit("R8 reset", out_valid, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_bit("R8 idle after reset", out_valid, 1'b0);

    // table walk, one operand at a time, mode alternating
    for (int i = 0; i < NV; i++) begin
      logic vx;
      vx = i[0];
      drive(i, vx);
      @(negedge clk);
      in_valid = 1'b0;
      chk_bit("R8 not yet", out_valid, 1'b0);
      @(negedge clk);
      chk_bit("R8 valid", out_valid, 1'b1);
      check_lane(i, vx);
      @(negedge clk);
      chk_bit("R8 single pulse", out_valid, 1'b0);
    end

    // back-to-back stream in order (R8), exact results (R9, R4)
    for (int c = 0; c < 5; c++) begin
      int sel [3];
      sel = '{0, 18, 1};
      if (c >= 2) begin
        chk_bit("R8 stream valid", out_valid, 1'b1);
        check_lane(sel[c-2], logic'((c - 2) % 2));
      end
      if (c < 3) drive(sel[c], logic'(c % 2));
      else       in_valid = 1'b0;
      @(negedge clk);
    end
    chk_bit("R8 stream drained", out_valid, 1'b0);

    // reset mid-flight clears valid (R8)
    drive(5, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk_bit("R8 reset in flight", out_valid, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_bit("R8 quiet after reset", out_valid, 1'b0);

    finish_run();
  end

endmodule